// File: doc/BRIEF.md
# Serial EEPROM Byte-Write Master with Acknowledge Polling

This block drives a two-wire serial bus as its only master. It stores one byte in a small serial EEPROM and then waits for the part's internal programming cycle to finish. A request supplies a word address and a data byte. The block then puts out a complete write frame on open-drain clock and data lines. The frame is a start, a device-select byte, the address byte, the data byte and a stop.

The block does not wait for a fixed programming time. It polls the target straight away. Each poll is a start followed by a write-direction select byte. The target answers with a NACK while it is still programming, and each NACK makes the block start again. When the target answers with an ACK, the block closes the bus with a stop and pulses `done`.

A NACK during the write frame itself ends the transaction with a stop and sets an error flag. A parameter can limit the number of polls. When that limit is reached, the block stops and sets a timeout flag instead.

Each line is driven through a drive-low enable and read back through an input. The bus clock comes from a quarter-period divider.

Top module: `eepw_poll_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, the block releases both lines (`scl_oe` = 0 and `sda_oe` = 0), so both lines rest high.
- R2: An accepted request produces the write frame in this order: start, select byte 0xA0, address byte, data byte, stop. The select byte is device code 1010 in bits 7..4, three zero bits, then R/W = 0 in bit 0. The address byte carries the 4-bit word address in bits 3..0 and zeros in bits 7..4. Every byte is sent MSB first, and a ninth clock follows each byte to read the acknowledge.
- R3: Right after the write frame's stop, the block sends start plus 0xA0. Each NACK to that poll is followed by another start plus 0xA0, with no stop in between. A target that NACKs b polls therefore sees b+2 starts in the whole transaction.
- R4: When a poll is acknowledged, the block sends a stop and then raises `done` for exactly one clock. `err` and `timeout` are low at that point.
- R5: A NACK on any byte of the write frame ends the transaction with a stop and sets `err`. No poll is sent and `done` stays low.
- R6: If `POLL_LIMIT` is N > 0 and N polls in a row get a NACK, the block sends a stop and sets `timeout`. `done` stays low.
- R7: The data line changes only while the clock line is low, except at start and stop. The bus therefore sees exactly one start per frame and exactly one stop per finished transaction.
- R8: A request is accepted only while `busy` is low. A request made while busy has no effect. `err` and `timeout` hold their value until the next request is accepted.
- R9: An acknowledge is a low data line, sampled while the clock line is high during the ninth clock of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Word address of the byte to write |
| req_data | input | 8 | Byte to write |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock pulse: the write is confirmed complete |
| err | output | 1 | Write frame was not acknowledged (held) |
| timeout | output | 1 | Poll limit reached without ACK (held) |
| scl_in | input | 1 | Sensed level of the clock line |
| scl_oe | output | 1 | Pull clock line low |
| sda_in | input | 1 | Sensed level of the data line |
| sda_oe | output | 1 | Pull data line low |

## Verification
Every bus action is built from quarter periods of DIV clocks each, so a byte with its acknowledge takes 36·DIV clocks.

`busy` rises one clock after a request is taken. The end result comes one clock after the last quarter of the final stop: `done`, `err` or `timeout` appears in the same cycle that `busy` falls.

The bench samples on the falling clock edge. It waits for `busy` to fall, counting `done` pulses on the way. It then reads the flags and checks that `done` is low again one clock later.

Bus-level effects are checked by a target model on the wires. The model counts starts, stops and committed writes, and it answers each select byte on the clock edge where the acknowledge is due.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      BUS_START,
      BUS_STOP,
      BUS_BYTE
   } bus_op_e;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_W_START,
      SQ_W_CTRL,
      SQ_W_ADDR,
      SQ_W_DATA,
      SQ_W_STOP,
      SQ_P_START,
      SQ_P_CTRL,
      SQ_END
   } seq_st_e;

   typedef enum logic [1:0] {
      END_OK,
      END_ERR,
      END_TMO
   } end_kind_e;
endpackage

// File: rtl/eepw_tick.sv
module eepw_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("eepw_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (cnt == CNT_W'(DIV - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = (cnt == CNT_W'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/eepw_bit_engine.sv
module eepw_bit_engine
   import eepw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              go,
   input  bus_op_e           op,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              sda_in,
   output logic              busy,
   output logic              done,
   output logic              ack,
   output logic              scl_lo,
   output logic              sda_lo
);
   localparam int BIT_W = $clog2(BYTE_W + 1);

   bus_op_e           op_q;
   logic [1:0]        qtr;
   logic [BIT_W-1:0]  bitn;
   logic [BYTE_W-1:0] sh;
   logic              last;

   assign last = (bitn == BIT_W'(BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         ack    <= 1'b0;
         scl_lo <= 1'b0;
         sda_lo <= 1'b0;
         op_q   <= BUS_START;
         qtr    <= '0;
         bitn   <= '0;
         sh     <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go) begin
               busy <= 1'b1;
               op_q <= op;
               sh   <= tx_byte;
               qtr  <= '0;
               bitn <= '0;
            end
         end else if (tick) begin
            unique case (op_q)
               BUS_START: begin
                  unique case (qtr)
                     2'd0: sda_lo <= 1'b0;
                     2'd1: scl_lo <= 1'b0;
                     2'd2: sda_lo <= 1'b1;
                     default: scl_lo <= 1'b1;
                  endcase
               end
               BUS_STOP: begin
                  unique case (qtr)
                     2'd0: begin
                        scl_lo <= 1'b1;
                        sda_lo <= 1'b1;
                     end
                     2'd1: scl_lo <= 1'b0;
                     2'd2: sda_lo <= 1'b0;
                     default: ;
                  endcase
               end
               default: begin
                  unique case (qtr)
                     2'd0: begin
                        scl_lo <= 1'b1;
                        sda_lo <= last ? 1'b0 : !sh[BYTE_W-1];
                     end
                     2'd1: scl_lo <= 1'b0;
                     2'd2: if (last) ack <= !sda_in;
                     default: begin
                        scl_lo <= 1'b1;
                        if (!last) sh <= sh << 1;
                     end
                  endcase
               end
            endcase
            qtr <= qtr + 1'b1;
            if (qtr == 2'd3) begin
               if (op_q != BUS_BYTE || last) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitn <= bitn + 1'b1;
               end
            end
         end
      end
   end

   // R7
   sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == BUS_BYTE && !$stable(sda_lo)) |-> (scl_lo && $past(scl_lo)));

   // R9
   ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q == BUS_BYTE && !$stable(ack)) |-> (last && !scl_lo));
endmodule

// File: rtl/eepw_poll_master.sv
module eepw_poll_master
   import eepw_pkg::*;
#(
   parameter int         DIV        = 4,
   parameter int         ADDR_W     = 4,
   parameter int         POLL_LIMIT = 0,
   parameter logic [3:0] DEV_CODE   = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BYTE_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              timeout,
   input  logic              scl_in,
   output logic              scl_oe,
   input  logic              sda_in,
   output logic              sda_oe
);
   localparam logic [BYTE_W-1:0] CTRL_BYTE = {DEV_CODE, 3'b000, 1'b0};
   localparam int TRY_W = (POLL_LIMIT > 0) ? $clog2(POLL_LIMIT + 1) : 1;

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("eepw_poll_master: ADDR_W must be 1..8");
      end
      if (POLL_LIMIT < 0) begin : g_bad_lim
         $error("eepw_poll_master: POLL_LIMIT must be non-negative");
      end
   endgenerate

   logic              tick, e_go, e_busy, e_done, e_ack;
   bus_op_e           e_op;
   logic [BYTE_W-1:0] e_byte;
   seq_st_e           st;
   end_kind_e         kind;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] data_q;
   logic [TRY_W-1:0]  tries;
   logic              limit_hit;
   logic              scl_unused;

   assign scl_unused = scl_in;

   eepw_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   eepw_bit_engine u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .go     (e_go),
      .op     (e_op),
      .tx_byte(e_byte),
      .sda_in (sda_in),
      .busy   (e_busy),
      .done   (e_done),
      .ack    (e_ack),
      .scl_lo (scl_oe),
      .sda_lo (sda_oe)
   );

   generate
      if (POLL_LIMIT == 0) begin : g_unlimited
         assign limit_hit = 1'b0;
      end else begin : g_limited
         assign limit_hit = (tries == TRY_W'(POLL_LIMIT));
         // R6
         try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tries <= TRY_W'(POLL_LIMIT));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         kind    <= END_OK;
         addr_q  <= '0;
         data_q  <= '0;
         tries   <= '0;
         e_go    <= 1'b0;
         e_op    <= BUS_START;
         e_byte  <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         timeout <= 1'b0;
      end else begin
         e_go <= 1'b0;
         done <= 1'b0;
         unique case (st)
            SQ_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               data_q  <= req_data;
               err     <= 1'b0;
               timeout <= 1'b0;
               tries   <= '0;
               e_go    <= 1'b1;
               e_op    <= BUS_START;
               st      <= SQ_W_START;
            end
            SQ_W_START: if (e_done) begin
               e_go   <= 1'b1;
               e_op   <= BUS_BYTE;
               e_byte <= CTRL_BYTE;
               st     <= SQ_W_CTRL;
            end
            SQ_W_CTRL, SQ_W_ADDR, SQ_W_DATA: if (e_done) begin
               e_go <= 1'b1;
               if (!e_ack) begin
                  e_op <= BUS_STOP;
                  kind <= END_ERR;
                  st   <= SQ_END;
               end else if (st == SQ_W_CTRL) begin
                  e_op   <= BUS_BYTE;
                  e_byte <= BYTE_W'(addr_q);
                  st     <= SQ_W_ADDR;
               end else if (st == SQ_W_ADDR) begin
                  e_op   <= BUS_BYTE;
                  e_byte <= data_q;
                  st     <= SQ_W_DATA;
               end else begin
                  e_op <= BUS_STOP;
                  st   <= SQ_W_STOP;
               end
            end
            SQ_W_STOP: if (e_done) begin
               e_go <= 1'b1;
               e_op <= BUS_START;
               st   <= SQ_P_START;
            end
            SQ_P_START: if (e_done) begin
               e_go   <= 1'b1;
               e_op   <= BUS_BYTE;
               e_byte <= CTRL_BYTE;
               tries  <= tries + 1'b1;
               st     <= SQ_P_CTRL;
            end
            SQ_P_CTRL: if (e_done) begin
               e_go <= 1'b1;
               if (e_ack) begin
                  e_op <= BUS_STOP;
                  kind <= END_OK;
                  st   <= SQ_END;
               end else if (limit_hit) begin
                  e_op <= BUS_STOP;
                  kind <= END_TMO;
                  st   <= SQ_END;
               end else begin
                  e_op <= BUS_START;
                  st   <= SQ_P_START;
               end
            end
            default: if (e_done) begin
               st      <= SQ_IDLE;
               done    <= (kind == END_OK);
               err     <= (kind == END_ERR);
               timeout <= (kind == END_TMO);
            end
         endcase
      end
   end

   assign busy = (st != SQ_IDLE);

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !e_busy) |-> (!scl_oe && !sda_oe));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!err && !timeout && !busy));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(addr_q) && $stable(data_q)));

   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && timeout));
endmodule

// File: tb/eepw_poll_master_tb.sv
module eepw_poll_master_tb;
   localparam int DIV   = 2;
   localparam int LIMIT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic       busy, done, err, timeout, scl_oe, sda_oe;
   logic       scl_w, sda_w;
   logic       s_sda_lo = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   // bench-side configuration of the target model
   int busy_cfg = 0;
   int nack_at  = 0;
   int arm_id   = 0;

   always #2.5 clk = ~clk;

   assign scl_w = ~scl_oe;
   assign sda_w = ~(sda_oe | s_sda_lo);

   eepw_poll_master #(.DIV(DIV), .ADDR_W(4), .POLL_LIMIT(LIMIT)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_addr (req_addr),
      .req_data (req_data),
      .busy     (busy),
      .done     (done),
      .err      (err),
      .timeout  (timeout),
      .scl_in   (scl_w),
      .scl_oe   (scl_oe),
      .sda_in   (sda_w),
      .sda_oe   (sda_oe)
   );

   // ---------------- target model ----------------
   int n_start = 0, n_stop = 0, n_wr = 0, n_badctrl = 0;
   logic [7:0] wr_addr = '0, wr_data = '0;
   int  busy_left = 0, arm_seen = 0, bitcnt = 0, byteno = 0;
   bit  first_frame = 0, ackph = 0, wr_pend = 0, ackv = 0;
   bit  prev_scl = 1, prev_sda = 1;
   logic [7:0] sh = '0, a_byte = '0, d_byte = '0;

   always @(scl_w or sda_w) begin
      if (scl_w === 1'b1 && prev_scl && prev_sda && sda_w === 1'b0) begin
         n_start++;
         bitcnt = 0; byteno = 0; ackph = 0; s_sda_lo = 1'b0; wr_pend = 0;
         if (arm_seen != arm_id) begin
            arm_seen = arm_id; first_frame = 1; busy_left = 0;
         end else begin
            first_frame = 0;
         end
      end else if (scl_w === 1'b1 && prev_scl && !prev_sda && sda_w === 1'b1) begin
         n_stop++;
         if (wr_pend) begin
            n_wr++; wr_addr = a_byte; wr_data = d_byte; busy_left = busy_cfg; wr_pend = 0;
         end
         bitcnt = 0; byteno = 0; ackph = 0;
      end else if (scl_w === 1'b1 && !prev_scl) begin
         if (!ackph) begin
            sh = {sh[6:0], sda_w}; bitcnt++;
         end
      end else if (scl_w === 1'b0 && prev_scl) begin
         if (ackph) begin
            ackph = 0; s_sda_lo = 1'b0;
         end else if (bitcnt == 8) begin
            bitcnt = 0; ackph = 1;
            case (byteno)
               0: begin
                  if (sh != 8'hA0) n_badctrl++;
                  ackv = (sh == 8'hA0) && !(first_frame && nack_at == 1);
                  if (!first_frame && busy_left > 0) begin
                     ackv = 0; busy_left--;
                  end
               end
               1: begin a_byte = sh; ackv = !(first_frame && nack_at == 2); end
               2: begin
                  d_byte = sh; ackv = !(first_frame && nack_at == 3);
                  wr_pend = ackv && first_frame;
               end
               default: ackv = 0;
            endcase
            s_sda_lo = ackv;
            byteno++;
         end
      end
      prev_scl = (scl_w === 1'b1);
      prev_sda = (sda_w === 1'b1);
   end

   // ---------------- checking ----------------
   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // kind: 0 = completes, 1 = frame error, 2 = poll timeout
   task automatic run_txn(input logic [3:0] a, input logic [7:0] d, input int b,
                          input int nk, input int kind, input bit poke);
      int s0, p0, w0, bc0, dcnt, cyc, ex_polls;
      bit seen;
      s0 = n_start; p0 = n_stop; w0 = n_wr; bc0 = n_badctrl;
      busy_cfg = b; nack_at = nk; arm_id++;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 busy after accept", int'(busy), 1);
      dcnt = 0; seen = 0; cyc = 0;
      while (cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 40) begin
            req_valid = 1'b1; req_addr = ~a; req_data = ~d;
         end else begin
            req_valid = 1'b0;
         end
         if (done) dcnt++;
         if (!busy) begin seen = 1; break; end
      end
      chk("R4 transaction ended", int'(seen), 1);
      chk("R4 done pulse count", dcnt, (kind == 0) ? 1 : 0);
      chk("R5 err flag", int'(err), (kind == 1) ? 1 : 0);
      chk("R6 timeout flag", int'(timeout), (kind == 2) ? 1 : 0);
      @(negedge clk);
      chk("R4 done one clock wide", int'(done), 0);
      chk("R1 bus released after", int'(scl_w & sda_w), 1);
      chk("R2 select byte 0xA0", n_badctrl - bc0, 0);
      ex_polls = (kind == 0) ? b + 1 : ((kind == 2) ? LIMIT : 0);
      chk("R3 R7 start count", n_start - s0, 1 + ex_polls);
      chk("R7 stop count", n_stop - p0, (kind == 1) ? 1 : 2);
      chk("R5 write committed", n_wr - w0, (kind == 1) ? 0 : 1);
      if (kind != 1) begin
         chk("R2 address byte", int'(wr_addr), int'({4'h0, a}));
         chk("R2 data byte", int'(wr_data), int'(d));
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset lines high", int'(scl_w & sda_w), 1);
      chk("R1 reset flags", int'(done | err | timeout), 0);

      // R2 R3 R4 sweep over every address, with busy depth a mod 4
      for (int a = 0; a < 16; a++) begin
         run_txn(4'(a), 8'((a * 37 + 5) & 255), a % 4, 0, 0, 0);
      end

      // R5 NACK on each byte of the write frame
      for (int k = 1; k <= 3; k++) begin
         run_txn(4'(k + 4), 8'(k * 51), 0, k, 1, 0);
      end
      // R8 err holds until next request
      chk("R8 err held", int'(err), 1);
      run_txn(4'd9, 8'h3C, 1, 0, 0, 0);

      // R6 timeout after LIMIT unacknowledged polls
      run_txn(4'd12, 8'hC5, LIMIT + 3, 0, 2, 0);
      repeat (10) @(negedge clk);
      chk("R8 timeout held", int'(timeout), 1);
      // R6 limit boundary: LIMIT-1 NACKs still finish
      run_txn(4'd13, 8'h5A, LIMIT - 1, 0, 0, 0);

      // R8 request while busy is ignored
      run_txn(4'd3, 8'h96, 2, 0, 0, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule